// File: doc/BRIEF.md
# Trap Restart Fixup Unit

When a memory fault stops an instruction part-way through, the machine state has to be rolled back so that the instruction can run again from its start once the fault is serviced. This unit does that rollback. A single fixup code names the correction. The program counter, which counts bytes, can be moved back by one, two or three bytes or forward by one byte. The stack depth can be lowered or raised by one or two entries. A double step takes one extra cycle.

After the correction, the unit splits the faulting virtual address into two fault parameter words. The low word is stored first and the high bank bits one cycle later. A one-cycle done strobe then tells the trap logic that follows that the corrected state and the parameters are ready. All inputs are captured in the cycle in which the start strobe is taken. A start that arrives while a fixup is in progress is ignored.

Top module: `tfx_restart_unit`

## Requirements
- R1: After reset, `pc_out`, `sp_out`, `fault_lo`, `fault_hi`, `done` and `stack_err` are all zero.
- R2: The corrected PC is the captured PC changed as the code selects, modulo 2^PC_W. Back 1 for codes 1, 4, 6 and 10. Back 2 for codes 2, 5, 7, 11 and 15. Back 3 for codes 3 and 12. Forward 1 for code 13. Unchanged for codes 0, 8, 9 and 14.
- R3: A pop lowers the stack depth by one and a push raises it by one. Codes 4, 5, 6, 7 and 8 pop. Codes 9, 10, 11, 12, 13, 14 and 15 push. Codes 0 to 3 leave the depth unchanged.
- R4: Codes 6, 7, 14 and 15 apply their stack step twice. The first step shows on `sp_out` one cycle after the cycle that took `start`, and the second step shows one cycle later.
- R5: `done` is a one-cycle pulse. It rises 4 cycles after the clock edge that took `start`, or 5 cycles after it for the double-step codes.
- R6: `fault_lo` takes the `addr_lo` value captured with `start`, one cycle before `done` rises. `fault_hi` takes the captured `addr_hi` in the following cycle, the same cycle in which `done` rises.
- R7: A code of 16 or above is treated like code 0. PC and stack depth are kept, and both fault parameters are still captured with normal timing.
- R8: A pop at depth 0 or a push at depth SP_MAX leaves the depth unchanged and sets `stack_err`. `stack_err` stays set until reset.
- R9: A `start` pulse taken while a fixup is in progress has no effect on the results or on the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fixup; the inputs are captured in the same cycle |
| fix_code | input | CODE_W | Fixup code selecting the PC and stack correction |
| pc_in | input | PC_W | Byte-granular program counter at the fault |
| sp_in | input | SP_W | Stack depth at the fault (0 to SP_MAX) |
| addr_lo | input | LO_W | Low word of the faulting address |
| addr_hi | input | HI_W | High bank bits of the faulting address |
| pc_out | output | PC_W | Corrected program counter |
| sp_out | output | SP_W | Corrected stack depth |
| fault_lo | output | LO_W | Fault parameter 0 |
| fault_hi | output | HI_W | Fault parameter 1 |
| done | output | 1 | One-cycle pulse when the fixup is complete |
| stack_err | output | 1 | Sticky flag for a stack step that saturated |

## Verification
A wrong decode entry shows up as a wrong `pc_out` or `sp_out` after the very next `done`. A sequencer state that is wrong in any way moves `done` by at least one cycle or duplicates it, and the bench measures the `done` position exactly. A misplaced second stack step is caught from `sp_out` two cycles after start. Lost saturation or a `stack_err` that fails to stay set appears after the first fixup that reaches a depth limit.

// File: rtl/tfx_pkg.sv
package tfx_pkg;
   typedef enum logic [2:0] {PC_KEEP, PC_BACK1, PC_BACK2, PC_BACK3, PC_FWD1} pc_op_e;
   typedef enum logic [1:0] {STK_NONE, STK_POP, STK_PUSH} stk_op_e;
   typedef struct packed {
      pc_op_e  pc_op;
      stk_op_e stk_op;
      logic    twice;
   } fix_t;
   typedef enum logic [2:0] {ST_IDLE, ST_ADJ, ST_EXTRA, ST_SEL, ST_P0, ST_P1} st_e;
endpackage

// File: rtl/tfx_decode.sv
module tfx_decode
   import tfx_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic [CODE_W-1:0] code,
   output fix_t              fix
);
   initial assert (CODE_W >= 4) else $error("tfx_decode: CODE_W must be at least 4");

   logic defined;

   generate
      if (CODE_W > 4) begin : g_wide
         assign defined = ~|code[CODE_W-1:4];
      end else begin : g_narrow
         assign defined = 1'b1;
      end
   endgenerate

   always_comb begin
      fix = '{pc_op: PC_KEEP, stk_op: STK_NONE, twice: 1'b0};
      if (defined) begin
         case (code[3:0])
            4'h1: fix.pc_op = PC_BACK1;
            4'h2: fix.pc_op = PC_BACK2;
            4'h3: fix.pc_op = PC_BACK3;
            4'h4: fix = '{pc_op: PC_BACK1, stk_op: STK_POP,  twice: 1'b0};
            4'h5: fix = '{pc_op: PC_BACK2, stk_op: STK_POP,  twice: 1'b0};
            4'h6: fix = '{pc_op: PC_BACK1, stk_op: STK_POP,  twice: 1'b1};
            4'h7: fix = '{pc_op: PC_BACK2, stk_op: STK_POP,  twice: 1'b1};
            4'h8: fix = '{pc_op: PC_KEEP,  stk_op: STK_POP,  twice: 1'b0};
            4'h9: fix = '{pc_op: PC_KEEP,  stk_op: STK_PUSH, twice: 1'b0};
            4'hA: fix = '{pc_op: PC_BACK1, stk_op: STK_PUSH, twice: 1'b0};
            4'hB: fix = '{pc_op: PC_BACK2, stk_op: STK_PUSH, twice: 1'b0};
            4'hC: fix = '{pc_op: PC_BACK3, stk_op: STK_PUSH, twice: 1'b0};
            4'hD: fix = '{pc_op: PC_FWD1,  stk_op: STK_PUSH, twice: 1'b0};
            4'hE: fix = '{pc_op: PC_KEEP,  stk_op: STK_PUSH, twice: 1'b1};
            4'hF: fix = '{pc_op: PC_BACK2, stk_op: STK_PUSH, twice: 1'b1};
            default: fix.pc_op = PC_KEEP;
         endcase
      end
   end
endmodule

// File: rtl/tfx_stack_step.sv
module tfx_stack_step
   import tfx_pkg::*;
#(
   parameter int SP_W   = 4,
   parameter int SP_MAX = 13
) (
   input  logic [SP_W-1:0] sp,
   input  stk_op_e         op,
   output logic [SP_W-1:0] sp_next,
   output logic            sat
);
   localparam logic [SP_W-1:0] TOP = SP_W'(SP_MAX);

   initial assert (SP_MAX > 0 && SP_MAX < (1 << SP_W))
      else $error("tfx_stack_step: SP_MAX must fit in SP_W bits");

   logic at_top;
   logic at_bot;

   generate
      if (SP_MAX == (1 << SP_W) - 1) begin : g_full_range
         assign at_top = &sp;
      end else begin : g_part_range
         assign at_top = (sp >= TOP);
      end
   endgenerate

   assign at_bot = (sp == '0);

   always_comb begin
      sp_next = sp;
      sat     = 1'b0;
      case (op)
         STK_POP:  if (at_bot) sat = 1'b1; else sp_next = sp - 1'b1;
         STK_PUSH: if (at_top) sat = 1'b1; else sp_next = sp + 1'b1;
         default:  sp_next = sp;
      endcase
   end
endmodule

// File: rtl/tfx_seq.sv
module tfx_seq
   import tfx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic twice,
   output st_e  state,
   output logic done
);
   st_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (start) nxt = ST_ADJ;
         ST_ADJ:   nxt = twice ? ST_EXTRA : ST_SEL;
         ST_EXTRA: nxt = ST_SEL;
         ST_SEL:   nxt = ST_P0;
         ST_P0:    nxt = ST_P1;
         ST_P1:    nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state == ST_P1);
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R5
   AST_P0_THEN_P1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_P0) |=> (state == ST_P1));                           // R6
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_P1) |=> (state != ST_ADJ));      // R9
endmodule

// File: rtl/tfx_restart_unit.sv
module tfx_restart_unit
   import tfx_pkg::*;
#(
   parameter int CODE_W = 5,
   parameter int PC_W   = 17,
   parameter int SP_W   = 4,
   parameter int SP_MAX = 13,
   parameter int LO_W   = 16,
   parameter int HI_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] fix_code,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [SP_W-1:0]   sp_in,
   input  logic [LO_W-1:0]   addr_lo,
   input  logic [HI_W-1:0]   addr_hi,
   output logic [PC_W-1:0]   pc_out,
   output logic [SP_W-1:0]   sp_out,
   output logic [LO_W-1:0]   fault_lo,
   output logic [HI_W-1:0]   fault_hi,
   output logic              done,
   output logic              stack_err
);
   localparam logic [PC_W-1:0] ONE   = PC_W'(1);
   localparam logic [PC_W-1:0] TWO   = PC_W'(2);
   localparam logic [PC_W-1:0] THREE = PC_W'(3);

   initial assert (PC_W >= 3 && LO_W > 0 && HI_W > 0)
      else $error("tfx_restart_unit: bad width parameters");

   st_e                state;
   logic [CODE_W-1:0]  code_q;
   logic [LO_W-1:0]    lo_q;
   logic [HI_W-1:0]    hi_q;
   fix_t               fix;
   logic [PC_W-1:0]    pc_fixed;
   logic [SP_W-1:0]    sp_step;
   logic               step_sat;
   logic               take;

   assign take = (state == ST_IDLE) && start;

   tfx_decode #(.CODE_W(CODE_W)) u_decode (
      .code (code_q),
      .fix  (fix)
   );

   tfx_stack_step #(.SP_W(SP_W), .SP_MAX(SP_MAX)) u_step (
      .sp      (sp_out),
      .op      (fix.stk_op),
      .sp_next (sp_step),
      .sat     (step_sat)
   );

   tfx_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .twice (fix.twice),
      .state (state),
      .done  (done)
   );

   always_comb begin
      case (fix.pc_op)
         PC_BACK1: pc_fixed = pc_out - ONE;
         PC_BACK2: pc_fixed = pc_out - TWO;
         PC_BACK3: pc_fixed = pc_out - THREE;
         PC_FWD1:  pc_fixed = pc_out + ONE;
         default:  pc_fixed = pc_out;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q    <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         pc_out    <= '0;
         sp_out    <= '0;
         fault_lo  <= '0;
         fault_hi  <= '0;
         stack_err <= 1'b0;
      end else begin
         if (take) begin
            code_q <= fix_code;
            lo_q   <= addr_lo;
            hi_q   <= addr_hi;
            pc_out <= pc_in;
            sp_out <= sp_in;
         end
         if (state == ST_ADJ) pc_out <= pc_fixed;
         if (state == ST_ADJ || state == ST_EXTRA) begin
            sp_out    <= sp_step;
            stack_err <= stack_err | step_sat;
         end
         if (state == ST_P0) fault_lo <= lo_q;
         if (state == ST_P1) fault_hi <= hi_q;
      end
   end

   AST_PC_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXTRA || state == ST_SEL || state == ST_P0 || state == ST_P1)
      |=> $stable(pc_out));                                             // R2
   AST_ONE_STACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADJ || state == ST_EXTRA) |=>
      (sp_out == $past(sp_out) || sp_out == $past(sp_out) + 1'b1 ||
       sp_out + 1'b1 == $past(sp_out)));                                // R3
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stack_err |=> stack_err);                                         // R8
   AST_LO_ONLY_IN_P0: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_P0) |=> $stable(fault_lo));                          // R6
endmodule

// File: tb/tfx_restart_unit_test.sv
module tfx_restart_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int CODE_W = 5;
   localparam int PC_W   = 17;
   localparam int SP_W   = 4;
   localparam int SP_MAX = 13;
   localparam int LO_W   = 16;
   localparam int HI_W   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CODE_W-1:0] fix_code = '0;
   logic [PC_W-1:0]   pc_in = '0;
   logic [SP_W-1:0]   sp_in = '0;
   logic [LO_W-1:0]   addr_lo = '0;
   logic [HI_W-1:0]   addr_hi = '0;
   logic [PC_W-1:0]   pc_out;
   logic [SP_W-1:0]   sp_out;
   logic [LO_W-1:0]   fault_lo;
   logic [HI_W-1:0]   fault_hi;
   logic              done;
   logic              stack_err;

   int checks = 0;
   int errors = 0;
   logic              m_err = 1'b0;
   logic [HI_W-1:0]   m_hi  = '0;

   tfx_restart_unit #(.CODE_W(CODE_W), .PC_W(PC_W), .SP_W(SP_W), .SP_MAX(SP_MAX),
                      .LO_W(LO_W), .HI_W(HI_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fix_code(fix_code), .pc_in(pc_in),
      .sp_in(sp_in), .addr_lo(addr_lo), .addr_hi(addr_hi), .pc_out(pc_out),
      .sp_out(sp_out), .fault_lo(fault_lo), .fault_hi(fault_hi), .done(done),
      .stack_err(stack_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reference model taken from the requirement text (R2, R3, R4, R7)
   function automatic int ref_pc_delta(input int c);
      case (c)
         1, 4, 6, 10:     return -1;
         2, 5, 7, 11, 15: return -2;
         3, 12:           return -3;
         13:              return 1;
         default:         return 0;
      endcase
   endfunction

   function automatic int ref_dir(input int c);
      if (c >= 4 && c <= 8) return -1;
      if (c >= 9 && c <= 15) return 1;
      return 0;
   endfunction

   function automatic bit ref_twice(input int c);
      return (c == 6 || c == 7 || c == 14 || c == 15);
   endfunction

   function automatic int ref_step(input int sp, input int dir, inout logic err);
      if (dir < 0) begin
         if (sp == 0) begin err = 1'b1; return sp; end
         return sp - 1;
      end
      if (dir > 0) begin
         if (sp == SP_MAX) begin err = 1'b1; return sp; end
         return sp + 1;
      end
      return sp;
   endfunction

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_err = 1'b0;
      m_hi  = '0;
   endtask

   task automatic run_op(input int c, input int pc, input int sp, input int lo, input int hi,
                         input bit poke);
      int dir, s1, s2, lat, seen, pulses;
      logic [PC_W-1:0] epc;
      dir  = ref_dir(c);
      s1   = ref_step(sp, dir, m_err);
      s2   = ref_twice(c) ? ref_step(s1, dir, m_err) : s1;
      lat  = ref_twice(c) ? 6 : 5;
      epc  = PC_W'(pc + ref_pc_delta(c));
      seen = 0;
      pulses = 0;
      @(negedge clk);
      fix_code = CODE_W'(c);
      pc_in    = PC_W'(pc);
      sp_in    = SP_W'(sp);
      addr_lo  = LO_W'(lo);
      addr_hi  = HI_W'(hi);
      start    = 1'b1;
      for (int n = 1; n <= 8; n++) begin
         @(negedge clk);
         if (n == 1) begin
            start    = poke;          // R9: taken while busy, must be ignored
            fix_code = CODE_W'($urandom);
            pc_in    = PC_W'($urandom);
            sp_in    = SP_W'($urandom_range(0, SP_MAX));
            addr_lo  = LO_W'($urandom);
            addr_hi  = HI_W'($urandom);
         end
         if (n == 2) begin
            start = 1'b0;
            chk(sp_out == SP_W'(s1), "R4 first stack step", sp_out, s1);
         end
         if (n == lat - 1) begin
            chk(fault_lo == LO_W'(lo), "R6 fault_lo", fault_lo, lo);
            chk(fault_hi == m_hi, "R6 fault_hi not yet", fault_hi, m_hi);
         end
         if (done) begin
            pulses++;
            if (seen == 0) seen = n;
         end
      end
      chk(seen == lat, "R5 done position", seen, lat);
      chk(pulses == 1, "R5 done single pulse", pulses, 1);
      chk(pc_out == epc, "R2 corrected pc", pc_out, epc);
      chk(sp_out == SP_W'(s2), "R3 corrected sp", sp_out, s2);
      chk(fault_lo == LO_W'(lo), "R6 param0", fault_lo, lo);
      chk(fault_hi == HI_W'(hi), "R6 param1", fault_hi, hi);
      chk(stack_err == m_err, "R8 stack_err", stack_err, m_err);
      m_hi = HI_W'(hi);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(pc_out == '0, "R1 pc_out", pc_out, 0);
      chk(sp_out == '0, "R1 sp_out", sp_out, 0);
      chk(fault_lo == '0 && fault_hi == '0, "R1 params", fault_lo, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(stack_err == 1'b0, "R1 stack_err", stack_err, 0);

      // every defined code once, from mid depth (R2, R3, R4)
      for (int c = 0; c < 16; c++) run_op(c, 1000 + c, 6, 16'hA000 + c, 8'h10 + c, 1'b0);
      // R7 undefined codes
      run_op(16, 777, 5, 16'h1234, 8'h56, 1'b0);
      run_op(31, 778, 5, 16'h4321, 8'h65, 1'b1);
      // R2 wrap around zero and top
      run_op(3, 1, 4, 16'h0001, 8'h01, 1'b0);
      run_op(13, (1 << PC_W) - 1, 4, 16'hFFFF, 8'hFF, 1'b0);
      // R9 poke during busy
      run_op(7, 500, 9, 16'h0BEE, 8'h33, 1'b1);
      // R8 saturation: pop2 from 1, then error stays set
      run_op(6, 200, 1, 16'h0002, 8'h02, 1'b0);
      run_op(9, 201, 3, 16'h0003, 8'h03, 1'b0);
      do_reset();
      run_op(14, 300, SP_MAX - 1, 16'h0004, 8'h04, 1'b0);
      do_reset();
      run_op(8, 400, 0, 16'h0005, 8'h05, 1'b0);
      do_reset();
      // constrained random
      for (int i = 0; i < 300; i++) begin
         if (i == 150) do_reset();
         run_op($urandom_range(0, 31), $urandom_range(0, (1 << PC_W) - 1),
                $urandom_range(0, SP_MAX), $urandom_range(0, 65535),
                $urandom_range(0, 255), 1'($urandom_range(0, 1)));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule